// File: doc/BRIEF.md
# RGB1555 Pixel Expander and Panel Packer

This block sits between a frame-fetch FIFO and a parallel RGB panel interface. Each cycle it can accept one 16-bit word that holds a pixel with 5-bit red, green and blue fields. It widens each field to 8 bits and optionally exchanges red and blue. It then packs the result for either an 18-bit or a 24-bit panel bus, with the colour order on the bus either normal or reversed. The 16-bit word is always read as RGB1555.

Both sides use a valid/ready handshake. A single register stage holds the packed pixel, and the stage is driven by a two-state machine. In ST_EMPTY no pixel is held. The transition LOAD (an input is accepted) moves it to ST_FULL. In ST_FULL a pixel is presented. From there, HOLD (output stalled) keeps it in ST_FULL, PASS (output taken while a new input is accepted) also stays in ST_FULL, and DRAIN (output taken with no new input) returns it to ST_EMPTY. The control inputs (fill mode, swap, reverse, panel type) are captured together with the pixel at the cycle it is accepted. A pixel already held in the stage is therefore not changed when those controls change later.

Top module: `pxl_fmt_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With fill_rep = 0, a 5-bit field c widens to the 8-bit value {c, 3'b000}.
- R3: With fill_rep = 1, a 5-bit field c widens to {c, c[4:2]}, so its top bits repeat into the new low bits.
- R4: With swap_rb = 1, the red field (word bits 14:10) and the blue field (word bits 4:0) exchange places before packing. Green (bits 9:5) is unaffected.
- R5: For any panel_type other than 3 (6 is the nominal 24-bit code), out_pix carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R6: With panel_type = 3, each widened channel contributes its upper 6 bits. They are packed as red in 17:12, green in 11:6 and blue in 5:0, and bits 23:18 are 0.
- R7: With reverse_rgb = 1, the channel that would occupy the top field occupies the bottom field and the reverse, for both bus widths. Green stays in the middle.
- R8: Bit 15 of in_word has no effect on out_pix.
- R9: The fill, swap, reverse and panel_type controls apply as sampled in the cycle the pixel is accepted (in_valid and in_ready both 1).
- R10: While out_valid = 1 and out_ready = 0, out_valid stays 1 and out_pix stays unchanged in the next cycle.
- R11: in_ready is 1 whenever out_ready is 1 or no pixel is held. With both sides always ready, one pixel passes per cycle, and an accepted pixel appears on out_pix in the next cycle.
- R12: Every accepted pixel is presented exactly once, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Stage can accept a pixel this cycle |
| in_word | input | 16 | RGB1555 word: red 14:10, green 9:5, blue 4:0, bit 15 unused |
| fill_rep | input | 1 | 0: zero low-bit fill, 1: replicate-fill |
| swap_rb | input | 1 | Exchange red and blue |
| reverse_rgb | input | 1 | Reverse component order on the output bus |
| panel_type | input | 4 | 3: 18-bit packing, other values: 24-bit packing |
| out_valid | output | 1 | Packed pixel present |
| out_ready | input | 1 | Panel side takes the pixel this cycle |
| out_pix | output | 24 | Packed panel pixel |

## Verification
The bench sweeps all 32 field values under all sixteen combinations of fill, swap, reverse and bus width. An error in replicate-fill would show as wrong low bits in only some codes. In 18-bit mode a wrong slice would show as shifted or truncated values in 17:0, or as stray bits in 23:18. Swap combined with reverse is covered too: applying the two in the wrong order, or letting one cancel the wrong channel, would misplace red against blue in exactly that combination. A randomized backpressure phase changes the controls every cycle and raises bit 15. That phase would expose a stage that reapplies live controls to a held pixel, drops or duplicates a pixel on a stall, or inserts a bubble while the output is ready.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_t;

    localparam logic [3:0] PANEL_NARROW = 4'd3;
    localparam logic [3:0] PANEL_WIDE   = 4'd6;

endpackage

// File: rtl/pxl_expand.sv
module pxl_expand #(
    parameter int CH_IN  = 5,
    parameter int CH_OUT = 8,
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0]   word_i,
    input  logic                fill_rep_i,
    input  logic                swap_rb_i,
    output logic [3*CH_OUT-1:0] rgb_o
);
    localparam int LOW = CH_OUT - CH_IN;

    logic [3*CH_IN-1:0] fields;

    // field order in the word: blue lowest, then green, then red
    always_comb begin
        fields = word_i[3*CH_IN-1:0];
        if (swap_rb_i) begin
            fields = {word_i[CH_IN-1:0], word_i[2*CH_IN-1:CH_IN],
                      word_i[3*CH_IN-1:2*CH_IN]};
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_chan
        logic [CH_IN-1:0] c;
        assign c = fields[k*CH_IN +: CH_IN];
        always_comb begin
            if (fill_rep_i) begin
                rgb_o[k*CH_OUT +: CH_OUT] = {c, c[CH_IN-1 -: LOW]};
            end else begin
                rgb_o[k*CH_OUT +: CH_OUT] = {c, {LOW{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/pxl_pack.sv
module pxl_pack #(
    parameter int CH_OUT = 8,
    parameter int NARROW = 6
) (
    input  logic [3*CH_OUT-1:0] rgb_i,
    input  logic                narrow_i,
    input  logic                reverse_i,
    output logic [3*CH_OUT-1:0] pix_o
);
    always_comb begin
        pix_o = '0;
        for (int k = 0; k < 3; k++) begin
            int src;
            src = reverse_i ? (2 - k) : k;
            if (narrow_i) begin
                pix_o[k*NARROW +: NARROW] = rgb_i[src*CH_OUT + CH_OUT - 1 -: NARROW];
            end else begin
                pix_o[k*CH_OUT +: CH_OUT] = rgb_i[src*CH_OUT +: CH_OUT];
            end
        end
    end

endmodule

// File: rtl/pxl_stage.sv
module pxl_stage
    import pxl_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    stage_st_t state_q, state_d;
    logic [W-1:0] data_q;
    logic         load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and handshake outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
                if (in_valid) state_d = ST_FULL;             // LOAD
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
                if (out_ready && !in_valid) state_d = ST_EMPTY; // DRAIN
                else                        state_d = ST_FULL;  // PASS / HOLD
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign load = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= in_data;
        end
    end

    assign out_data = data_q;

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r11_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    a_r11_load_shows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r12_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/pxl_fmt_packer.sv
module pxl_fmt_packer
    import pxl_pkg::*;
#(
    parameter int CH_IN  = 5,
    parameter int CH_OUT = 8,
    parameter int NARROW = 6,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                fill_rep,
    input  logic                swap_rb,
    input  logic                reverse_rgb,
    input  logic [3:0]          panel_type,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [3*CH_OUT-1:0] out_pix
);
    localparam int PIX_W = 3 * CH_OUT;
    localparam int LOW   = CH_OUT - CH_IN;

    logic [PIX_W-1:0] rgb_wide;
    logic [PIX_W-1:0] packed_pix;
    logic             narrow;

    assign narrow = (panel_type == PANEL_NARROW);

    pxl_expand #(.CH_IN(CH_IN), .CH_OUT(CH_OUT), .WORD_W(WORD_W)) u_expand (
        .word_i     (in_word),
        .fill_rep_i (fill_rep),
        .swap_rb_i  (swap_rb),
        .rgb_o      (rgb_wide)
    );

    pxl_pack #(.CH_OUT(CH_OUT), .NARROW(NARROW)) u_pack (
        .rgb_i     (rgb_wide),
        .narrow_i  (narrow),
        .reverse_i (reverse_rgb),
        .pix_o     (packed_pix)
    );

    pxl_stage #(.W(PIX_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (packed_pix),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_pix)
    );

    a_r6_narrow_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && panel_type == PANEL_NARROW)
        |=> (out_pix[PIX_W-1:3*NARROW] == '0));

    a_r2_zero_fill_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !fill_rep && panel_type != PANEL_NARROW)
        |=> (out_pix[LOW-1:0] == '0 && out_pix[CH_OUT+LOW-1 -: LOW] == '0
             && out_pix[2*CH_OUT+LOW-1 -: LOW] == '0));

    a_r8_bit15_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && $stable(in_word[WORD_W-2:0]) && $stable(fill_rep)
         && $stable(swap_rb) && $stable(reverse_rgb) && $stable(panel_type)
         && $past(in_valid && in_ready))
        |=> $stable(out_pix));

endmodule

// File: tb/pxl_fmt_packer_bench.sv
module pxl_fmt_packer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic        fill_rep = 1'b0;
    logic        swap_rb = 1'b0;
    logic        reverse_rgb = 1'b0;
    logic [3:0]  panel_type = 4'd6;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_pix;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];
    bit          prev_hold = 1'b0;
    logic [23:0] prev_pix = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pxl_fmt_packer u_pxl_fmt_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .fill_rep(fill_rep), .swap_rb(swap_rb),
        .reverse_rgb(reverse_rgb), .panel_type(panel_type),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
    );

    function automatic int widen(int c, bit rep, bit nar);
        int e;
        e = rep ? (c * 8 + c / 4) : (c * 8);
        return nar ? (e / 4) : e;
    endfunction

    function automatic logic [23:0] model(int w, bit rep, bit sw, bit rev, bit nar);
        int r, g, b, t, sh, hi, lo;
        r = (w / 1024) % 32;
        g = (w / 32) % 32;
        b = w % 32;
        if (sw) begin t = r; r = b; b = t; end
        r = widen(r, rep, nar);
        g = widen(g, rep, nar);
        b = widen(b, rep, nar);
        sh = nar ? 64 : 256;
        hi = rev ? b : r;
        lo = rev ? r : b;
        return 24'(hi * sh * sh + g * sh + lo);
    endfunction

    function automatic string tag_of(int w, bit rep, bit sw, bit rev, bit nar);
        string s;
        s = "R12 R9";
        s = {s, rep ? " R3" : " R2"};
        s = {s, nar ? " R6" : " R5"};
        if (sw) s = {s, " R4"};
        if (rev) s = {s, " R7"};
        if (w >= 32768) s = {s, " R8"};
        return s;
    endfunction

    task automatic step(bit v, int w, int cfg, bit ordy);
        @(negedge clk);
        in_valid    = v;
        in_word     = 16'(w);
        fill_rep    = cfg[0];
        swap_rb     = cfg[1];
        reverse_rgb = cfg[2];
        panel_type  = cfg[3] ? 4'd3 : ((cfg % 3 == 0) ? 4'd6 : 4'd9);
        out_ready   = ordy;
        #1;
        if (prev_hold) begin
            checks++;
            if (!(out_valid && out_pix == prev_pix)) begin
                fails++;
                $display("FAIL R10 held pixel changed: valid=%0b pix=%h expected pix=%h",
                         out_valid, out_pix, prev_pix);
            end
        end
        if (out_ready || !out_valid) begin
            checks++;
            if (!in_ready) begin
                fails++;
                $display("FAIL R11 in_ready=%0b expected 1", in_ready);
            end
        end
        if (out_valid && out_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R12 unexpected pixel %h expected none", out_pix);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_pix !== e) begin
                    fails++;
                    $display("FAIL %s pixel %h expected %h", t, out_pix, e);
                end
            end
        end
        if (in_valid && in_ready) begin
            bit nar;
            nar = (panel_type == 4'd3);
            exp_q.push_back(model(w, fill_rep, swap_rb, reverse_rgb, nar));
            tag_q.push_back(tag_of(w, fill_rep, swap_rb, reverse_rgb, nar));
        end
        prev_hold = out_valid && !out_ready;
        prev_pix  = out_pix;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 out_valid=%0b in_ready=%0b expected 0 and 1", out_valid, in_ready);
        end

        // exhaustive field sweep, both sides ready (R11 full rate)
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int v = 0; v < 32; v++) begin
                int w;
                w = v * 1024 + ((31 - v) * 32) + ((v * 7 + 3) % 32);
                if (v % 5 == 0) w += 32768;
                step(1'b1, w, cfg, 1'b1);
            end
        end
        step(1'b0, 0, 0, 1'b1);

        // randomized backpressure, controls changing every cycle
        begin
            int  w;
            int  cfg;
            bit  pend;
            pend = 1'b0;
            w = 0;
            cfg = 0;
            for (int n = 0; n < 3000; n++) begin
                bit v;
                if (!pend) begin
                    w = int'($urandom_range(0, 65535));
                    v = ($urandom_range(0, 3) != 0);
                end else begin
                    v = 1'b1;
                end
                cfg = int'($urandom_range(0, 15));
                step(v, w, cfg, ($urandom_range(0, 2) != 0));
                pend = v && !in_ready;
            end
        end

        // drain
        for (int n = 0; n < 20 && exp_q.size() != 0; n++) begin
            step(1'b0, 0, 0, 1'b1);
        end
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R12 %0d pixels never presented, expected 0", exp_q.size());
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule